// File: doc/BRIEF.md
# Level-Acknowledge Parallel Handshake Controller

This block runs one side of a two-wire request/acknowledge handshake on a parallel port. It drives the acknowledge wire to its active level whenever it can take part in a transfer and holds that level until the far end makes an active-going edge on the request wire. That edge ends the transfer: acknowledge drops at once, and the block stays unacknowledged until it is ready again and an optional programmable settling interval has passed.

In the receive direction the request edge captures the word on the parallel input pins and hands it to a consumer over a valid/ready interface; acknowledge is not raised again until that word has been taken. In the send direction a producer offers words over a valid/ready interface; each accepted word is driven on the parallel output pins either straight away or, with request-edge latching selected, only at the request edge that closes the transfer. The request wire is synchronized with two flops, the active level of each wire is selectable, and a request edge seen while acknowledge is inactive is dropped and flagged in a sticky error bit.

Top module: `lvlack_hs_ctrl`

## Requirements
- R1: While rst_ni is low, ack_o sits at its inactive level (ack_o equals cfg_ack_low_i), rx_valid_o is 0 and err_o is 0; after reset in receive direction (cfg_dir_out_i = 0) ack_o goes active without any request.
- R2: An active-going request edge while ack is active drops ack; with req_i changed between clock edges, ack_o changes on the third rising clock edge after the change.
- R3: In receive direction, the word on port_d_i at the request edge appears on rx_data_o with rx_valid_o = 1 and is held unchanged until a cycle with rx_ready_i = 1.
- R4: Ack is not raised again while a captured word is still unconsumed (receive) or while no send word is offered (send).
- R5: cfg_req_low_i = 1 makes the falling edge of req_i the active edge; cfg_ack_low_i = 1 makes ack_o low when active (ack_o = active XOR cfg_ack_low_i).
- R6: The settling interval is cfg_dly_i (0 to 7) times STEP_CYC clock cycles; in receive direction with rx_ready_i held high ack stays inactive for exactly 2 + cfg_dly_i*STEP_CYC cycles per transfer; in send direction ack goes active cfg_dly_i*STEP_CYC cycles after the edge that accepts the word.
- R7: In send direction (cfg_dir_out_i = 1) tx_ready_o is 1 only while ack is inactive and no settling is in progress; with cfg_out_latch_i = 0 the accepted word drives port_d_o from the accepting edge on.
- R8: In send direction with cfg_out_latch_i = 1, port_d_o keeps its previous value while the new word is acknowledged and takes the accepted word on the request edge that ends the transfer.
- R9: A request edge while ack is inactive captures nothing and sets err_o; err_o stays set until err_clr_i is high in a cycle without such an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_dir_out_i | input | 1 | 0 receive, 1 send |
| cfg_req_low_i | input | 1 | Request wire active low |
| cfg_ack_low_i | input | 1 | Acknowledge wire active low |
| cfg_dly_i | input | DLY_W | Settling interval in steps |
| cfg_out_latch_i | input | 1 | Send direction: update pins on request edge |
| req_i | input | 1 | Request wire from the far end (asynchronous) |
| ack_o | output | 1 | Acknowledge wire to the far end |
| port_d_i | input | W | Parallel input pins |
| port_d_o | output | W | Parallel output pins |
| rx_data_o | output | W | Captured word |
| rx_valid_o | output | 1 | Captured word pending |
| rx_ready_i | input | 1 | Consumer takes the word |
| tx_data_i | input | W | Word to send |
| tx_valid_i | input | 1 | Send word offered |
| tx_ready_o | output | 1 | Send word accepted this cycle if valid |
| err_o | output | 1 | Sticky request-while-unacknowledged flag |
| err_clr_i | input | 1 | Clear the error flag |

## Verification
The bench builds the block with W = 8 and STEP_CYC = 3, so the whole delay range 0 to 7 maps to 0 to 21 extra cycles and the exact acknowledge gap can be counted cycle by cycle at settings 0, 5 and 7 within a short run. The 8-bit width lets all-zero, all-one and mixed words cross the receive path, and both polarity settings are driven after a fresh reset so the falling-edge request and low-active acknowledge cases are reached alongside the default ones.

// File: rtl/lvlack_pkg.sv
package lvlack_pkg;
  typedef enum logic [1:0] {
    HS_WAIT   = 2'd0,
    HS_SETTLE = 2'd1,
    HS_ACKED  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/lvlack_req_sync.sv
module lvlack_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic act_low_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              act;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= req_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], req_i};
      end
    end
  endgenerate

  assign act = sync_q[STAGES-1] ^ act_low_i;

  // prev starts "active" so no edge is seen until request has been inactive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= act;
  end

  assign edge_o = act & ~prev_q;
endmodule

// File: rtl/lvlack_settle_timer.sv
module lvlack_settle_timer #(
  parameter int unsigned STEP_CYC = 10,
  parameter int unsigned DLY_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             zero_o,
  output logic             last_o
);
  localparam int unsigned MAX_LEN = ((1 << DLY_W) - 1) * STEP_CYC;
  localparam int unsigned CNT_W   = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] len;
  logic [CNT_W-1:0] cnt_q;

  assign len    = CNT_W'(dly_i) * CNT_W'(STEP_CYC);
  assign zero_o = (len == '0);
  assign last_o = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= len;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/lvlack_hs_fsm.sv
module lvlack_hs_fsm
  import lvlack_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  input  logic req_edge_i,
  input  logic tmr_zero_i,
  input  logic tmr_last_i,
  output logic start_o,
  output logic wait_o,
  output logic ack_act_o,
  output logic capture_o,
  output logic stray_o
);
  hs_state_e state_q, state_d;

  assign wait_o    = (state_q == HS_WAIT);
  assign ack_act_o = (state_q == HS_ACKED);
  assign start_o   = wait_o & ready_i;
  assign capture_o = ack_act_o & req_edge_i;
  assign stray_o   = ~ack_act_o & req_edge_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_WAIT:   if (ready_i) state_d = tmr_zero_i ? HS_ACKED : HS_SETTLE;
      HS_SETTLE: if (tmr_last_i) state_d = HS_ACKED;
      HS_ACKED:  if (req_edge_i) state_d = HS_WAIT;
      default:   state_d = HS_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HS_WAIT;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/lvlack_hs_ctrl.sv
module lvlack_hs_ctrl #(
  parameter int unsigned W        = 8,
  parameter int unsigned DLY_W    = 3,
  parameter int unsigned STEP_CYC = 10,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_dir_out_i,
  input  logic             cfg_req_low_i,
  input  logic             cfg_ack_low_i,
  input  logic [DLY_W-1:0] cfg_dly_i,
  input  logic             cfg_out_latch_i,
  input  logic             req_i,
  output logic             ack_o,
  input  logic [W-1:0]     port_d_i,
  output logic [W-1:0]     port_d_o,
  output logic [W-1:0]     rx_data_o,
  output logic             rx_valid_o,
  input  logic             rx_ready_i,
  input  logic [W-1:0]     tx_data_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  output logic             err_o,
  input  logic             err_clr_i
);
  logic req_edge, ready, start, in_wait, ack_act, capture, stray;
  logic tmr_zero, tmr_last, accept;
  logic [W-1:0] stage_q;

  lvlack_req_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .act_low_i(cfg_req_low_i),
    .edge_o   (req_edge)
  );

  lvlack_settle_timer #(.STEP_CYC(STEP_CYC), .DLY_W(DLY_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .dly_i  (cfg_dly_i),
    .zero_o (tmr_zero),
    .last_o (tmr_last)
  );

  lvlack_hs_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ready_i   (ready),
    .req_edge_i(req_edge),
    .tmr_zero_i(tmr_zero),
    .tmr_last_i(tmr_last),
    .start_o   (start),
    .wait_o    (in_wait),
    .ack_act_o (ack_act),
    .capture_o (capture),
    .stray_o   (stray)
  );

  assign ready      = cfg_dir_out_i ? tx_valid_i : ~rx_valid_o;
  assign tx_ready_o = cfg_dir_out_i & in_wait;
  assign accept     = tx_ready_o & tx_valid_i;
  assign ack_o      = ack_act ^ cfg_ack_low_i;

  // receive path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else if (capture && !cfg_dir_out_i) begin
      rx_data_o  <= port_d_i;
      rx_valid_o <= 1'b1;
    end else if (rx_valid_o && rx_ready_i) begin
      rx_valid_o <= 1'b0;
    end
  end

  // send path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q  <= '0;
      port_d_o <= '0;
    end else begin
      if (accept) stage_q <= tx_data_i;
      if (accept && !cfg_out_latch_i)
        port_d_o <= tx_data_i;
      else if (capture && cfg_dir_out_i && cfg_out_latch_i)
        port_d_o <= stage_q;
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_o <= 1'b0;
    else if (stray)     err_o <= 1'b1;
    else if (err_clr_i) err_o <= 1'b0;
  end
endmodule

module lvlack_hs_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cfg_dir_out_i,
  input logic         cfg_out_latch_i,
  input logic         req_edge,
  input logic         ack_act,
  input logic         rx_valid_o,
  input logic         rx_ready_i,
  input logic [W-1:0] rx_data_o,
  input logic         tx_ready_o,
  input logic [W-1:0] port_d_o,
  input logic         err_o,
  input logic         err_clr_i
);
  // R2
  ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_act && req_edge |=> !ack_act);
  // R3
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && !rx_ready_i |=> rx_valid_o && $stable(rx_data_o));
  // R4
  no_ack_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_dir_out_i && rx_valid_o |-> !ack_act);
  // R7
  tx_ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> !ack_act);
  // R8
  out_latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_dir_out_i && cfg_out_latch_i && !(ack_act && req_edge) |=> $stable(port_d_o));
  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !err_clr_i |=> err_o);
  // R9
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_edge && !ack_act |=> err_o);
endmodule

bind lvlack_hs_ctrl lvlack_hs_chk #(.W(W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_dir_out_i  (cfg_dir_out_i),
  .cfg_out_latch_i(cfg_out_latch_i),
  .req_edge       (req_edge),
  .ack_act        (ack_act),
  .rx_valid_o     (rx_valid_o),
  .rx_ready_i     (rx_ready_i),
  .rx_data_o      (rx_data_o),
  .tx_ready_o     (tx_ready_o),
  .port_d_o       (port_d_o),
  .err_o          (err_o),
  .err_clr_i      (err_clr_i)
);

// File: tb/lvlack_hs_ctrl_tb.sv
module lvlack_hs_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int DLY_W = 3;
  localparam int STEP = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_dir_out_i = 0, cfg_req_low_i = 0, cfg_ack_low_i = 0, cfg_out_latch_i = 0;
  logic [DLY_W-1:0] cfg_dly_i = '0;
  logic req_i = 0, ack_o, rx_valid_o, rx_ready_i = 1, tx_valid_i = 0, tx_ready_o;
  logic err_o, err_clr_i = 0;
  logic [W-1:0] port_d_i = '0, port_d_o, rx_data_o, tx_data_i = '0;

  int total = 0, bad = 0, cyc = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] out_q[$];
  logic [W-1:0] last_out;

  lvlack_hs_ctrl #(.W(W), .DLY_W(DLY_W), .STEP_CYC(STEP)) dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit ack_on();
    return ack_o ^ cfg_ack_low_i;
  endfunction

  task automatic set_req(input bit act);
    req_i = act ^ cfg_req_low_i;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL R1 watchdog act=%0d exp=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // monitor: receive scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && rx_valid_o && rx_ready_i) begin
      if (exp_q.size() == 0) check(0, "R3 unexpected word", rx_data_o, 0);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(rx_data_o == e, "R3 rx word", rx_data_o, e);
      end
    end
  end

  task automatic wait_ack(input bit lvl);
    for (int i = 0; i < 200; i++) begin
      if (ack_on() == lvl) return;
      @(negedge clk_i);
    end
    check(0, "R4 ack wait timeout", ack_on(), lvl);
  endtask

  task automatic do_reset(input bit dir, input bit rlow, input bit alow);
    @(negedge clk_i);
    rst_ni = 0;
    cfg_dir_out_i = dir; cfg_req_low_i = rlow; cfg_ack_low_i = alow;
    cfg_dly_i = '0; cfg_out_latch_i = 0; tx_valid_i = 0; rx_ready_i = 1;
    set_req(0);
    repeat (3) @(negedge clk_i);
    check(ack_o == alow, "R1 ack inactive in reset", ack_o, alow);
    check(rx_valid_o == 0 && err_o == 0, "R1 flags in reset", {rx_valid_o, err_o}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
  endtask

  // driver: receive transfer
  task automatic in_xfer(input logic [W-1:0] w, input bit chk_gap, input int gap);
    int n;
    wait_ack(1);
    port_d_i = w;
    exp_q.push_back(w);
    set_req(1);
    @(negedge clk_i);
    @(negedge clk_i);
    check(ack_on() == 1, "R2 ack held before third edge", ack_on(), 1);
    @(negedge clk_i);
    check(ack_on() == 0, "R2 ack drops on third edge", ack_on(), 0);
    set_req(0);
    if (chk_gap) begin
      n = 1;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk_i);
        if (ack_on()) break;
        n++;
      end
      check(n == gap, "R6 ack gap", n, gap);
    end
  endtask

  // driver: send transfer; peripheral pops and checks the pins
  task automatic out_xfer(input logic [W-1:0] w, input int pre_cyc);
    int n;
    logic [W-1:0] e;
    wait_ack(0);
    tx_data_i = w; tx_valid_i = 1;
    out_q.push_back(w);
    check(tx_ready_o == 1, "R7 tx_ready while idle", tx_ready_o, 1);
    @(negedge clk_i);
    tx_valid_i = 0;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      if (ack_on()) break;
      n++;
      @(negedge clk_i);
    end
    check(n == pre_cyc, "R6 send settle", n, pre_cyc);
    check(tx_ready_o == 0, "R7 tx_ready low while acked", tx_ready_o, 0);
    e = out_q.pop_front();
    if (cfg_out_latch_i)
      check(port_d_o == last_out, "R8 pins hold old word", port_d_o, last_out);
    else
      check(port_d_o == e, "R7 pins show word", port_d_o, e);
    set_req(1);
    repeat (3) @(negedge clk_i);
    check(ack_on() == 0, "R2 send ack drop", ack_on(), 0);
    check(port_d_o == e, "R8 pins after request edge", port_d_o, e);
    last_out = e;
    set_req(0);
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    do_reset(0, 0, 0);
    check(ack_on() == 1, "R1 ack active after reset", ack_o, 1);
    in_xfer(8'hA5, 1, 2);
    in_xfer(8'h3C, 1, 2);
    in_xfer(8'h00, 1, 2);
    in_xfer(8'hFF, 1, 2);
    cfg_dly_i = 3'd5;
    in_xfer(8'h11, 1, 2 + 5*STEP);
    cfg_dly_i = 3'd7;
    in_xfer(8'h22, 1, 2 + 7*STEP);
    cfg_dly_i = 3'd0;
    // stalled consumer, then stray request edge
    wait_ack(1);
    rx_ready_i = 0;
    in_xfer(8'h5A, 0, 0);
    repeat (10) @(negedge clk_i);
    check(ack_on() == 0, "R4 ack held off while word pending", ack_on(), 0);
    check(rx_valid_o == 1 && rx_data_o == 8'h5A, "R3 word held", rx_data_o, 8'h5A);
    port_d_i = 8'hEE;
    set_req(1);
    repeat (4) @(negedge clk_i);
    check(err_o == 1, "R9 stray edge flagged", err_o, 1);
    check(rx_data_o == 8'h5A, "R9 stray edge captures nothing", rx_data_o, 8'h5A);
    set_req(0);
    repeat (3) @(negedge clk_i);
    rx_ready_i = 1;
    @(negedge clk_i);
    repeat (5) @(negedge clk_i);
    check(err_o == 1, "R9 flag sticky", err_o, 1);
    err_clr_i = 1;
    @(negedge clk_i);
    err_clr_i = 0;
    check(err_o == 0, "R9 flag cleared", err_o, 0);
    check(exp_q.size() == 0, "R3 all words consumed", exp_q.size(), 0);

    // inverted polarities
    do_reset(0, 1, 1);
    check(ack_o == 0, "R5 low-active ack level", ack_o, 0);
    in_xfer(8'h69, 1, 2);
    in_xfer(8'h96, 1, 2);
    check(req_i == 1, "R5 request idles high", req_i, 1);

    // send direction
    do_reset(1, 0, 0);
    last_out = '0;
    check(ack_on() == 0, "R4 no ack without send word", ack_on(), 0);
    out_xfer(8'hC3, 0);
    out_xfer(8'h81, 0);
    repeat (10) @(negedge clk_i);
    check(ack_on() == 0, "R4 ack stays off with no word", ack_on(), 0);
    cfg_dly_i = 3'd2;
    out_xfer(8'h7E, 2*STEP);
    cfg_dly_i = 3'd0;
    cfg_out_latch_i = 1;
    out_xfer(8'h4D, 0);
    out_xfer(8'hB2, 0);
    check(err_o == 0, "R9 no stray edges in send run", err_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule